// File: doc/BRIEF.md
# Voice Record and Playback Sequencer

This block sequences a compressed-voice memory. Two active-low requests, one for recording and one for playback, come from the user side. While recording, the block enables the speech encoder and has the code RAM store one 4-bit code per 8 kHz sample at rising addresses. While playing, it enables the decoder and reads the same addresses back in the same order. Every output is driven from the 8 kHz sample clock.

The block never grants both functions at once. Each session begins with a single-cycle reset pulse to the codec it is about to use, and the address is cleared when the session starts. The address space covers a fixed span of two seconds, which is 16000 codes. The last address written in a session is kept as an end mark, and playback stops there. After a full buffer or a finished playback, the memory stays deselected until the request is released.

No data passes through this block. The codes go straight from the encoder to the RAM and from the RAM to the decoder, so every pin here is a plain control level and there is no valid/ready handshake or back-pressure.

Top module: `voice_rec_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all enables, resets, `ram_cs` and `ram_we` are 0 and `ram_addr` is 0.
- R2: From idle, `rec_req_n` sampled low gives one cycle with `enc_rst`=1 and `ram_addr`=0. The next cycles show `enc_en`=1, `ram_cs`=1 and `ram_we`=1, with `ram_addr` starting at 0 and rising by 1 each cycle.
- R3: `enc_en` and `dec_en` are never 1 together. If both requests are sampled low in idle, recording starts.
- R4: Requests are accepted only from idle. A play request during recording and a record request during playback have no effect on the outputs.
- R5: When `rec_req_n` is sampled high during recording, the code at the current address is still written. In the next cycle `enc_en`, `ram_cs` and `ram_we` are 0, and that address becomes the end mark.
- R6: After address 15999 is written with the request still held, `enc_en`, `ram_cs` and `ram_we` stay 0 until `rec_req_n` is released. 15999 becomes the end mark.
- R7: From idle, `play_req_n` sampled low gives one cycle with `dec_rst`=1 and `ram_addr`=0. The next cycles show `dec_en`=1, `ram_cs`=1 and `ram_we`=0, with the address starting at 0 and rising by 1.
- R8: After the end-mark address is read with the request still held, `dec_en` and `ram_cs` stay 0 until `play_req_n` is released.
- R9: When `play_req_n` is sampled high during playback, `dec_en` and `ram_cs` drop in the next cycle.
- R10: If the request is released during the codec-reset cycle, the block returns to idle without any memory access, and the end mark is unchanged.
- R11: `ram_we` is 1 only when `ram_cs` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_8k | input | 1 | 8 kHz sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_req_n | input | 1 | Record request, active low |
| play_req_n | input | 1 | Play request, active low |
| enc_en | output | 1 | Encoder enable |
| enc_rst | output | 1 | Encoder reset pulse |
| dec_en | output | 1 | Decoder enable |
| dec_rst | output | 1 | Decoder reset pulse |
| ram_cs | output | 1 | Code RAM select, 1 = access |
| ram_we | output | 1 | Code RAM write enable, 1 = write, 0 = read |
| ram_addr | output | 14 | Code RAM address |

## Verification
A table of record lengths paired with playback hold times covers three cases: playback that reaches the end mark, playback cut short by release, and the two being equal. Each read count must match the shorter of the two. Directed runs start both requests together to confirm record priority, and assert the opposite request mid-session to show it is ignored. A release in the reset cycle is followed by a playback whose length proves that the old end mark survived. A full 16000-sample recording separates the buffer-full stop from a normal release, and the playback that follows shows that the end mark lands exactly on the last address.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC_INIT,
    ST_REC_RUN,
    ST_REC_FULL,
    ST_PLAY_INIT,
    ST_PLAY_RUN,
    ST_PLAY_DONE
  } vrc_state_e;

  typedef enum logic [1:0] {
    GRANT_NONE,
    GRANT_REC,
    GRANT_PLAY
  } vrc_grant_e;
endpackage

// File: rtl/vrc_req_arb.sv
module vrc_req_arb
  import vrc_pkg::*;
(
  input  logic       rec_on,
  input  logic       play_on,
  input  logic       idle,
  output vrc_grant_e grant
);
  // record wins a tie; nothing is granted outside idle
  always_comb begin
    grant = GRANT_NONE;
    if (idle) begin
      if (rec_on)       grant = GRANT_REC;
      else if (play_on) grant = GRANT_PLAY;
    end
  end
endmodule

// File: rtl/vrc_addr_ctr.sv
module vrc_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int DEPTH  = 16000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              end_cap,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] end_mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clear) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_mark <= '0;
    end else if (end_cap) begin
      end_mark <= addr;
    end
  end

  assign at_last = (addr == LAST_ADDR);
  assign at_end  = (addr == end_mark);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (addr == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (addr == $past(addr) + 1'b1));
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= LAST_ADDR);
endmodule

// File: rtl/vrc_seq.sv
module vrc_seq
  import vrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rec_on,
  input  logic       play_on,
  input  vrc_grant_e grant,
  input  logic       at_last,
  input  logic       at_end,
  output logic       idle,
  output logic       addr_clr,
  output logic       addr_step,
  output logic       end_cap,
  output logic       enc_en,
  output logic       enc_rst,
  output logic       dec_en,
  output logic       dec_rst,
  output logic       ram_cs,
  output logic       ram_we
);
  vrc_state_e state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (grant == GRANT_REC)       state_nx = ST_REC_INIT;
        else if (grant == GRANT_PLAY) state_nx = ST_PLAY_INIT;
      end
      ST_REC_INIT:  state_nx = rec_on ? ST_REC_RUN : ST_IDLE;
      ST_REC_RUN: begin
        if (!rec_on)     state_nx = ST_IDLE;
        else if (at_last) state_nx = ST_REC_FULL;
      end
      ST_REC_FULL:  if (!rec_on) state_nx = ST_IDLE;
      ST_PLAY_INIT: state_nx = play_on ? ST_PLAY_RUN : ST_IDLE;
      ST_PLAY_RUN: begin
        if (!play_on)    state_nx = ST_IDLE;
        else if (at_end) state_nx = ST_PLAY_DONE;
      end
      ST_PLAY_DONE: if (!play_on) state_nx = ST_IDLE;
      default:      state_nx = ST_IDLE;
    endcase
  end

  assign idle      = (state == ST_IDLE);
  assign addr_clr  = idle && (grant != GRANT_NONE);
  assign addr_step = ((state == ST_REC_RUN)  && rec_on  && !at_last) ||
                     ((state == ST_PLAY_RUN) && play_on && !at_end);
  assign end_cap   = (state == ST_REC_RUN) && (!rec_on || at_last);

  assign enc_en  = (state == ST_REC_RUN);
  assign enc_rst = (state == ST_REC_INIT);
  assign dec_en  = (state == ST_PLAY_RUN);
  assign dec_rst = (state == ST_PLAY_INIT);
  assign ram_cs  = (state == ST_REC_RUN) || (state == ST_PLAY_RUN);
  assign ram_we  = (state == ST_REC_RUN);

  p_enc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_rst |=> !enc_rst);
  p_dec_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_rst |=> !dec_rst);
  p_rec_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && rec_on) |=> enc_rst);
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_en && rec_on) |=> !dec_en && !dec_rst);
  p_full_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_en && rec_on && at_last) |=> !ram_cs);
  p_end_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && play_on && at_end) |=> !ram_cs);
  p_play_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !play_on) |=> !dec_en);
endmodule

// File: rtl/voice_rec_ctrl.sv
module voice_rec_ctrl #(
  parameter int ADDR_W  = 14,
  parameter int RATE_HZ = 8000,
  parameter int REC_SEC = 2
) (
  input  logic              clk_8k,
  input  logic              rst_n,
  input  logic              rec_req_n,
  input  logic              play_req_n,
  output logic              enc_en,
  output logic              enc_rst,
  output logic              dec_en,
  output logic              dec_rst,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr
);
  import vrc_pkg::*;

  localparam int DEPTH = RATE_HZ * REC_SEC;

  logic       rec_on, play_on, idle;
  logic       addr_clr, addr_step, end_cap, at_last, at_end;
  vrc_grant_e grant;

  assign rec_on  = !rec_req_n;
  assign play_on = !play_req_n;

  vrc_req_arb u_arb (
    .rec_on  (rec_on),
    .play_on (play_on),
    .idle    (idle),
    .grant   (grant)
  );

  vrc_seq u_seq (
    .clk       (clk_8k),
    .rst_n     (rst_n),
    .rec_on    (rec_on),
    .play_on   (play_on),
    .grant     (grant),
    .at_last   (at_last),
    .at_end    (at_end),
    .idle      (idle),
    .addr_clr  (addr_clr),
    .addr_step (addr_step),
    .end_cap   (end_cap),
    .enc_en    (enc_en),
    .enc_rst   (enc_rst),
    .dec_en    (dec_en),
    .dec_rst   (dec_rst),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we)
  );

  vrc_addr_ctr #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_addr (
    .clk     (clk_8k),
    .rst_n   (rst_n),
    .clear   (addr_clr),
    .step    (addr_step),
    .end_cap (end_cap),
    .addr    (ram_addr),
    .at_last (at_last),
    .at_end  (at_end)
  );

  p_excl_r3: assert property (@(posedge clk_8k) disable iff (!rst_n)
    $onehot0({enc_en, dec_en}));
  p_we_cs_r11: assert property (@(posedge clk_8k) disable iff (!rst_n)
    ram_we |-> ram_cs);
  p_rec_release_r5: assert property (@(posedge clk_8k) disable iff (!rst_n)
    (enc_en && !rec_on) |=> (!ram_cs && $stable(ram_addr)));
endmodule

// File: tb/voice_rec_ctrl_test.sv
module voice_rec_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAST       = 15999;
  localparam logic [5:0] O_OFF   = 6'b000000;
  localparam logic [5:0] O_RINIT = 6'b010000;
  localparam logic [5:0] O_RRUN  = 6'b100011;
  localparam logic [5:0] O_PINIT = 6'b000100;
  localparam logic [5:0] O_PRUN  = 6'b001010;
  // record length, play hold cycles, expected reads
  localparam int VEC [5][3] = '{'{5, 100, 5}, '{5, 3, 3}, '{1, 10, 1},
                                '{12, 12, 12}, '{40, 7, 7}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_req_n = 1'b1;
  logic        play_req_n = 1'b1;
  logic        enc_en, enc_rst, dec_en, dec_rst, ram_cs, ram_we;
  logic [13:0] ram_addr;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  voice_rec_ctrl uut (
    .clk_8k     (clk),
    .rst_n      (rst_n),
    .rec_req_n  (rec_req_n),
    .play_req_n (play_req_n),
    .enc_en     (enc_en),
    .enc_rst    (enc_rst),
    .dec_en     (dec_en),
    .dec_rst    (dec_rst),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr)
  );

  function automatic logic [5:0] outs();
    return {enc_en, enc_rst, dec_en, dec_rst, ram_cs, ram_we};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_record(input int n, input string req);
    rec_req_n = 1'b0;
    nxt();
    chk(req, "record init outputs", outs(), O_RINIT);
    chk(req, "record init address", ram_addr, 0);
    for (int i = 0; i < n; i++) begin
      nxt();
      chk(req, "record run outputs", outs(), O_RRUN);
      chk(req, "record address", ram_addr, i);
      if (i == n - 1) rec_req_n = 1'b1;
    end
    nxt();
    chk("R5", "after record release", outs(), O_OFF);
  endtask

  task automatic do_play(input int hold, input int exp_reads, input string req);
    play_req_n = 1'b0;
    nxt();
    chk(req, "play init outputs", outs(), O_PINIT);
    chk(req, "play init address", ram_addr, 0);
    for (int i = 0; i < exp_reads; i++) begin
      nxt();
      chk(req, "play run outputs", outs(), O_PRUN);
      chk(req, "play address", ram_addr, i);
      if (i == hold - 1) play_req_n = 1'b1;
    end
    nxt();
    chk(play_req_n ? "R9" : "R8", "after last read", outs(), O_OFF);
    if (!play_req_n) begin
      for (int k = 0; k < 3; k++) begin
        nxt();
        chk("R8", "held at end mark", outs(), O_OFF);
      end
      play_req_n = 1'b1;
      nxt();
      chk("R8", "after play release", outs(), O_OFF);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    nxt();
    nxt();
    chk("R1", "outputs in reset", outs(), O_OFF);
    chk("R1", "address in reset", ram_addr, 0);
    rst_n = 1'b1;
    nxt();
    chk("R1", "outputs after reset", outs(), O_OFF);

    // table of record length vs play hold (R2, R5, R7, R8, R9, R11)
    for (int k = 0; k < 5; k++) begin
      do_record(VEC[k][0], "R2");
      do_play(VEC[k][1], VEC[k][2], "R7");
    end

    // R3: both requests together, record wins; R4: play held is ignored
    rec_req_n  = 1'b0;
    play_req_n = 1'b0;
    nxt();
    chk("R3", "tie goes to record", outs(), O_RINIT);
    for (int i = 0; i < 4; i++) begin
      nxt();
      chk("R4", "play ignored while recording", outs(), O_RRUN);
      chk("R4", "record address", ram_addr, i);
      if (i == 3) begin
        rec_req_n  = 1'b1;
        play_req_n = 1'b1;
      end
    end
    nxt();
    chk("R5", "record stopped", outs(), O_OFF);

    // R4: record request during playback is ignored
    play_req_n = 1'b0;
    nxt();
    chk("R7", "play init", outs(), O_PINIT);
    rec_req_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      nxt();
      chk("R4", "record ignored while playing", outs(), O_PRUN);
      chk("R4", "play address", ram_addr, i);
    end
    nxt();
    chk("R8", "stopped at end mark", outs(), O_OFF);
    play_req_n = 1'b1;
    nxt();
    chk("R8", "idle after play release", outs(), O_OFF);

    // R10: record request still low starts a session, released in init cycle
    nxt();
    chk("R10", "record init from held request", outs(), O_RINIT);
    rec_req_n = 1'b1;
    nxt();
    chk("R10", "abort without access", outs(), O_OFF);
    nxt();
    chk("R10", "still idle", outs(), O_OFF);
    do_play(100, 4, "R10");

    // R6: full buffer, then R8 playback of the whole span
    rec_req_n = 1'b0;
    nxt();
    chk("R6", "full record init", outs(), O_RINIT);
    for (int i = 0; i <= LAST; i++) begin
      nxt();
      chk("R6", "full record run", outs(), O_RRUN);
      chk("R6", "full record address", ram_addr, i);
    end
    for (int k = 0; k < 4; k++) begin
      nxt();
      chk("R6", "writes stop when full", outs(), O_OFF);
    end
    rec_req_n = 1'b1;
    nxt();
    chk("R6", "idle after full release", outs(), O_OFF);
    do_play(20000, LAST + 1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule